// File: doc/BRIEF.md
# Thrash-Free Least-Laxity Task Selector

This block chooses the next task for a processor from a fixed pool of task slots. Each slot has three inputs: a signed slack value, an unsigned remaining-deadline value and a two-bit status. On each time-base tick the selector finds the lowest slack among the runnable slots. It does this with a bit-serial minimum search that runs from the most significant bit down. A second bit-serial pass then picks the earliest deadline among the slots that tie on that slack. The block reports the chosen slot with a one-cycle done strobe.

Plain least-laxity scheduling lets tied tasks swap the processor on every tick. To prevent this, the selector keeps a lockout mask. When a decision is made, every other slot that tied with the winner is locked out. A locked slot still counts in the slack search. While the minimum-slack set contains a locked slot and the current holder is still running, the selector keeps the holder in place. The lock is dropped in two cases: the holder stops running, or some runnable slot shows slack strictly below every locked slot.

Control and status pins are plain signals. No stream interface crosses this boundary. The result is a strobe with no back-pressure, and the host samples it in the cycle that done is high. The task inputs are level inputs that the host holds steady while a decision is in progress.

Top module: `llsel_top`

## Requirements
- R1: A decision starts only on a clock edge where `tick_i` is high and the selector is idle. A tick that arrives during a decision has no effect and does not cause a second done strobe.
- R2: `done_o` is a one-cycle pulse. It is high in the cycle that follows the (2*W+2)-th rising edge after the edge that sampled the tick. This latency is the same whether or not any slots tie.
- R3: Status encoding is 0 suspended, 1 waiting, 2 ready, 3 running. Only slots with status 2 or 3 can be chosen or enter the minimum-slack set.
- R4: Slack is a W-bit two's complement value. The chosen slot has the smallest slack among eligible slots, so a negative slack beats any positive one.
- R5: Among eligible slots that share the smallest slack, the slot with the smallest unsigned deadline wins. If deadlines are also equal, the lowest slot index wins.
- R6: After a fresh selection, `lock_o` holds exactly the other slots of the minimum-slack set (bit i for slot i). The winner's own bit is clear.
- R7: Suppose the previous winner has status 3 and the minimum-slack set contains a slot whose `lock_o` bit is set. Then the result repeats the previous winner and leaves `lock_o` unchanged.
- R8: If the minimum-slack set contains no locked slot, the lock is released and a fresh selection under R5 and R6 is made. This is the case when a runnable slot has slack strictly below all locked slots.
- R9: If the previous winner's status is not 3 when a decision completes, the old lock has no effect and a fresh selection is made.
- R10: With no eligible slot, the decision reports `found_o`=0, `sel_id_o`=0 and `lock_o`=0.
- R11: After reset, `done_o`, `found_o`, `sel_id_o` and `lock_o` are all zero.
- R12: `found_o`, `sel_id_o` and `lock_o` change only in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick; starts a decision when idle |
| slack_i | input | NTASK*W | Signed slack per slot; slot i at bits [i*W +: W] |
| deadline_i | input | NTASK*W | Unsigned remaining deadline per slot |
| status_i | input | 2*NTASK | Status per slot; slot i at bits [2*i +: 2] |
| done_o | output | 1 | One-cycle strobe when a decision result is valid |
| found_o | output | 1 | High when a slot was chosen |
| sel_id_o | output | log2(NTASK) | Index of the chosen slot |
| lock_o | output | NTASK | Lockout mask, one bit per slot |

## Verification
The assertions assume that slack, deadline and status do not change from the tick edge until the done strobe. They also assume that a status value has meaning only in its two-bit field. The bench respects this: it changes the task inputs only while the selector is idle, after the strobe, and it injects ticks in mid-decision only to check that they are ignored. Random slack and deadline values come from narrow ranges, so ties, lock holds and releases occur often. Directed cases add negative slack, non-eligible slots with low slack, a holder that stops running, and an empty pool.

// File: rtl/llsel_pkg.sv
package llsel_pkg;
  typedef enum logic [1:0] {
    ST_SUSP  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_RUN   = 2'd3
  } tstat_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SLACK,
    PH_CAPT,
    PH_DEAD,
    PH_UPD
  } phase_e;
endpackage

// File: rtl/llsel_bitfilter.sv
// One step of the bit-serial minimum search: of the surviving candidates,
// keep those with a zero in the current bit column, unless none has one.
module llsel_bitfilter #(
  parameter int N = 32
) (
  input  logic [N-1:0] cand_i,
  input  logic [N-1:0] col_i,
  output logic [N-1:0] cand_o
);
  logic [N-1:0] zeros;

  always_comb begin
    zeros  = cand_i & ~col_i;
    cand_o = (|zeros) ? zeros : cand_i;
  end
endmodule

// File: rtl/llsel_prienc.sv
// Lowest-index priority encoder.
module llsel_prienc #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/llsel_lock.sv
// Result and lockout register: decides between holding the current task
// and issuing a fresh pick from the deadline survivors.
module llsel_lock #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_i,
  input  logic [N-1:0]  tie_i,
  input  logic [N-1:0]  win_i,
  input  logic          holder_run_i,
  output logic          done_o,
  output logic          found_o,
  output logic [IW-1:0] sel_o,
  output logic [N-1:0]  lock_o
);
  logic [N-1:0]  lock_q;
  logic [IW-1:0] sel_q;
  logic          found_q;
  logic          done_q;
  logic [N-1:0]  eff_lock;
  logic          hold;
  logic [IW-1:0] pick;
  logic          pick_any;

  llsel_prienc #(.N(N), .IW(IW)) u_pick (
    .req_i (win_i),
    .idx_o (pick),
    .any_o (pick_any)
  );

  always_comb begin
    eff_lock = holder_run_i ? lock_q : '0;
    hold     = |(tie_i & eff_lock);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= '0;
      sel_q   <= '0;
      found_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= upd_i;
      if (upd_i) begin
        if (hold) begin
          found_q <= 1'b1;
        end else if (!pick_any) begin
          found_q <= 1'b0;
          sel_q   <= '0;
          lock_q  <= '0;
        end else begin
          found_q <= 1'b1;
          sel_q   <= pick;
          lock_q  <= tie_i & ~(N'(1) << pick);
        end
      end
    end
  end

  assign done_o  = done_q;
  assign found_o = found_q;
  assign sel_o   = sel_q;
  assign lock_o  = lock_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_WINNER_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && found_q) |-> !lock_q[sel_q]); // R6
  AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !found_q) |-> (lock_q == '0 && sel_q == '0)); // R10
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> ($stable(lock_q) && $stable(sel_q) && $stable(found_q))); // R12
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && hold) |=> (sel_q == $past(sel_q) && lock_q == $past(lock_q))); // R7
endmodule

// File: rtl/llsel_top.sv
module llsel_top #(
  parameter int NTASK = 32,
  parameter int W     = 16,
  localparam int IW   = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int CW   = (W > 1) ? $clog2(W) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [NTASK*W-1:0] slack_i,
  input  logic [NTASK*W-1:0] deadline_i,
  input  logic [2*NTASK-1:0] status_i,
  output logic               done_o,
  output logic               found_o,
  output logic [IW-1:0]      sel_id_o,
  output logic [NTASK-1:0]   lock_o
);
  import llsel_pkg::*;

  phase_e           ph_q;
  logic [CW-1:0]    bit_q;
  logic [NTASK-1:0] cand_q;
  logic [NTASK-1:0] tie_q;
  logic [NTASK-1:0] elig;
  logic [NTASK-1:0] col_s;
  logic [NTASK-1:0] col_d;
  logic [NTASK-1:0] col;
  logic [NTASK-1:0] filt;
  logic             top_bit;
  logic             holder_run;

  assign top_bit = (bit_q == CW'(W - 1));

  // Slack is compared as offset binary: the sign bit is inverted on the top column.
  for (genvar t = 0; t < NTASK; t++) begin : g_col
    assign elig[t]  = status_i[2*t+1];
    assign col_s[t] = slack_i[t*W + int'(bit_q)] ^ top_bit;
    assign col_d[t] = deadline_i[t*W + int'(bit_q)];
  end

  assign col        = (ph_q == PH_DEAD) ? col_d : col_s;
  assign holder_run = (status_i[2*int'(sel_id_o) +: 2] == ST_RUN);

  llsel_bitfilter #(.N(NTASK)) u_filt (
    .cand_i (cand_q),
    .col_i  (col),
    .cand_o (filt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      cand_q <= '0;
      tie_q  <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (tick_i) begin
          cand_q <= elig;
          bit_q  <= CW'(W - 1);
          ph_q   <= PH_SLACK;
        end
        PH_SLACK: begin
          cand_q <= filt;
          if (bit_q == '0) ph_q <= PH_CAPT;
          else             bit_q <= bit_q - 1'b1;
        end
        PH_CAPT: begin
          tie_q <= cand_q;
          bit_q <= CW'(W - 1);
          ph_q  <= PH_DEAD;
        end
        PH_DEAD: begin
          cand_q <= filt;
          if (bit_q == '0) ph_q <= PH_UPD;
          else             bit_q <= bit_q - 1'b1;
        end
        PH_UPD:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  llsel_lock #(.N(NTASK), .IW(IW)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_i        (ph_q == PH_UPD),
    .tie_i        (tie_q),
    .win_i        (cand_q),
    .holder_run_i (holder_run),
    .done_o       (done_o),
    .found_o      (found_o),
    .sel_o        (sel_id_o),
    .lock_o       (lock_o)
  );

  AST_DEAD_WITHIN_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DEAD) |-> ((cand_q & ~tie_q) == '0)); // R5
  AST_UPD_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_UPD) |=> done_o); // R2
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SLACK) |=> (ph_q == PH_SLACK || ph_q == PH_CAPT)); // R1
  AST_DONE_ONLY_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(ph_q) == PH_UPD)); // R2
endmodule

// File: tb/llsel_top_bench.sv
`timescale 1ns/1ps
module llsel_top_bench;
  localparam int N  = 32;
  localparam int W  = 16;
  localparam int IW = $clog2(N);
  localparam int LAT = 2*W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N*W-1:0] slack_flat, dl_flat;
  logic [2*N-1:0] st_flat;
  logic done, found;
  logic [IW-1:0] sel_id;
  logic [N-1:0] lock;

  logic signed [W-1:0] sl [N];
  logic [W-1:0] dl [N];
  logic [1:0]   st [N];

  int n_tests = 0;
  int n_fail  = 0;

  logic [IW-1:0] ref_id;
  logic [N-1:0]  ref_lock;
  logic          e_found;
  logic [IW-1:0] e_id;
  logic [N-1:0]  e_lock;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      slack_flat[i*W +: W] = sl[i];
      dl_flat[i*W +: W]    = dl[i];
      st_flat[2*i +: 2]    = st[i];
    end
  end

  llsel_top #(.NTASK(N), .W(W)) u_llsel_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .slack_i(slack_flat), .deadline_i(dl_flat), .status_i(st_flat),
    .done_o(done), .found_o(found), .sel_id_o(sel_id), .lock_o(lock)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic expect_next();
    int smin = 0;
    bit any = 0;
    logic [N-1:0] minset = '0;
    logic [N-1:0] effl;
    int best;
    for (int i = 0; i < N; i++)
      if (st[i] >= 2'd2 && (!any || int'(sl[i]) < smin)) begin smin = int'(sl[i]); any = 1; end
    for (int i = 0; i < N; i++)
      if (st[i] >= 2'd2 && int'(sl[i]) == smin) minset[i] = 1'b1;
    effl = (st[ref_id] == 2'd3) ? ref_lock : '0;
    if (minset == '0) begin
      e_found = 0; e_id = '0; e_lock = '0;
    end else if ((minset & effl) != '0) begin
      e_found = 1; e_id = ref_id; e_lock = ref_lock;
    end else begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (minset[i] && (best < 0 || dl[i] < dl[best])) best = i;
      e_found = 1; e_id = IW'(best);
      e_lock = minset & ~(N'(1) << best);
    end
  endtask

  task automatic decide(input string tag, input bit busy_tick);
    logic [IW-1:0] p_id = sel_id;
    logic [N-1:0]  p_lock = lock;
    logic          p_found = found;
    bit early = 0, moved = 0, extra = 0;
    expect_next();
    tick = 1'b1;
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      if (k == 1) tick = 1'b0;
      if (busy_tick && k == 5) tick = 1'b1;
      if (busy_tick && k == 6) tick = 1'b0;
      if (k <= LAT) begin
        if (done) early = 1;
        if (sel_id !== p_id || lock !== p_lock || found !== p_found) moved = 1;
      end
    end
    chk("R2 latency", {63'd0, early}, 64'd0);
    chk("R12 stable", {63'd0, moved}, 64'd0);
    chk("R2 done", {63'd0, done}, 64'd1);
    chk({tag, " found"}, {63'd0, found}, {63'd0, e_found});
    chk({tag, " id"}, 64'(sel_id), 64'(e_id));
    chk({tag, " R6 lock"}, 64'(lock), 64'(e_lock));
    ref_id = e_id; ref_lock = e_lock;
    @(negedge clk);
    chk("R2 pulse", {63'd0, done}, 64'd0);
    if (busy_tick) begin
      for (int k = 0; k < LAT + 4; k++) begin
        @(negedge clk);
        if (done) extra = 1;
      end
      chk("R1 busy tick", {63'd0, extra}, 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin sl[i] = '0; dl[i] = '0; st[i] = 2'd0; end
    ref_id = '0; ref_lock = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 done", {63'd0, done}, 64'd0);
    chk("R11 found", {63'd0, found}, 64'd0);
    chk("R11 id", 64'(sel_id), 64'd0);
    chk("R11 lock", 64'(lock), 64'd0);

    decide("R10", 0);                                   // empty pool
    st[3] = 2'd2; sl[3] = -16'sd1; dl[3] = 16'd9;       // R3 R4
    st[4] = 2'd0; sl[4] = -16'sd5;
    st[5] = 2'd1; sl[5] = -16'sd6;
    st[6] = 2'd2; sl[6] = 16'sd2;
    decide("R3 R4", 0);
    st[3] = 2'd0; sl[6] = 16'sd8;                        // R5 tie on slack and deadline
    st[1] = 2'd2; sl[1] = 16'sd5; dl[1] = 16'd20;
    st[2] = 2'd2; sl[2] = 16'sd5; dl[2] = 16'd10;
    st[7] = 2'd2; sl[7] = 16'sd5; dl[7] = 16'd10;
    decide("R5", 0);
    st[2] = 2'd3; sl[1] = 16'sd4; sl[7] = 16'sd4;       // R7 hold
    decide("R7", 0);
    st[9] = 2'd2; sl[9] = 16'sd1;                        // R8 strictly smaller
    decide("R8", 0);
    st[9] = 2'd0; st[2] = 2'd2; sl[2] = 16'sd9;
    decide("R5 R6", 0);
    st[7] = 2'd3; sl[1] = 16'sd3;
    decide("R7 again", 0);
    st[7] = 2'd1;                                        // R9 holder leaves running
    decide("R9", 1);

    for (int n = 0; n < 150; n++) begin
      for (int i = 0; i < N; i++) begin
        st[i] = 2'($urandom_range(3));
        sl[i] = W'(int'($urandom_range(4)) - 2);
        dl[i] = W'($urandom_range(3));
      end
      if ($urandom_range(1) == 1) st[ref_id] = 2'd3;
      decide("R4 R5 R7 R8 random", (n % 25) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule